// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block runs the stack and program-flow part of a small 8-bit processor. It owns the stack pointer, the program counter and the interrupt master enable. It takes one decoded command at a time, together with an optional 16-bit target and a 16-bit register-pair value. It then steps through a fixed number of cycles and moves one byte per cycle over a memory port that has a 16-bit address. The supported commands are push and pop of a register pair, push and pop of accumulator plus flags, call, return, return with interrupt enable, absolute jump, jump through a register pair, and restart to a fixed vector.

Instruction fetch, condition evaluation and the memory are outside the block. The memory must return read data combinationally for the address on the port and must write the byte at the clock edge when the write enable is high. Popped pairs are presented on a result output once the command has finished.

Top module: `stack_flow_seq`

## Requirements
- R1: After reset the stack pointer is SP_INIT (default 0xFFFE), the program counter is PC_INIT (default 0x0100), the interrupt enable is 0, and busy, done, mem_we and mem_re are all 0.
- R2: Command codes on cmd_op are: 1 push pair, 2 push accumulator+flags, 3 pop pair, 4 pop accumulator+flags, 5 call, 6 return, 7 return with interrupt enable, 8 absolute jump, 9 jump through pair, 10 restart. Any other code is ignored. A command is accepted only at an edge where cmd_valid is high and the block is idle. Commands presented while the block is busy are ignored.
- R3: Counted from the edge that accepts the command, busy is high for N cycles and done is high only in cycle N. N is 4 for both pushes, 3 for both pops, 6 for call, 4 for both returns, 4 for absolute jump, 1 for jump through pair and 4 for restart.
- R4: A push writes cmd_pair[15:8] to SP-1 in cycle 2, then cmd_pair[7:0] to SP-2 in cycle 3, and leaves SP lowered by 2.
- R5: Push of accumulator+flags, with cmd_pair = {A, F}, writes A first. It then writes the flag byte with only bits 7..4 (zero, subtract, half-carry, carry) kept and bits 3..0 written as 0.
- R6: A pop reads the low byte at SP in cycle 1 and the high byte at SP+1 in cycle 2, and leaves SP raised by 2. After done, pop_pair holds {high, low}.
- R7: Pop of accumulator+flags takes the first byte read as flags and the second as accumulator. pop_pair = {A, F & 0xF0}.
- R8: A call pushes PC+3 (high byte in cycle 4, low byte in cycle 5) and then sets PC to cmd_target.
- R9: A return pops the new PC, low byte first. Return with interrupt enable does the same and also sets ime to 1.
- R10: An absolute jump sets PC to cmd_target. A jump through pair sets PC to cmd_pair. Neither touches memory or SP.
- R11: A restart pushes PC+1 in cycles 2 and 3 and sets PC to cmd_target[2:0] * 8.
- R12: mem_we and mem_re are never high together. PC changes only at the edge that ends a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 4 | Command code |
| cmd_target | input | 16 | Jump/call target, or restart vector index in bits 2..0 |
| cmd_pair | input | 16 | Register pair value (push data, or jump address) |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | Final cycle of a command |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |
| ime | output | 1 | Interrupt master enable |
| pop_pair | output | 16 | Last popped register pair |

## Verification
The main sequence interleaves pushes and pops, so each pop must return the bytes of the matching push in the right order. A swapped high/low byte therefore shows up as a byte-reversed pair. Pushing and popping accumulator+flags with a flag value whose low nibble is non-zero separates correct packing from a plain copy. Calls and restarts are checked against returns and stored bytes, which tells PC+3 apart from PC+1 and checks the vector scaling. The cycle counts are measured for every command. Separate tests drive a command during a busy period and an unused code, and confirm that neither one changes the state.

// File: rtl/stack_flow_seq.sv
module stack_flow_seq #(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] SP_INIT = 16'hFFFE,
  parameter logic [2*DW-1:0] PC_INIT = 16'h0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [2*DW-1:0] cmd_target,
  input  logic [2*DW-1:0] cmd_pair,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] sp,
  output logic [2*DW-1:0] pc,
  output logic            ime,
  output logic [2*DW-1:0] pop_pair
);
  localparam int AW = 2 * DW;
  localparam logic [3:0] OP_PUSH = 4'd1, OP_PUSHF = 4'd2, OP_POP = 4'd3, OP_POPF = 4'd4,
                         OP_CALL = 4'd5, OP_RET = 4'd6, OP_RETI = 4'd7, OP_JP = 4'd8,
                         OP_JPR = 4'd9, OP_RST = 4'd10;

  logic [3:0]    op_q, cnt, len;
  logic [AW-1:0] tgt_q, data_q;
  logic [DW-1:0] lo_q, hi_q;
  logic          push_like, pop_like, is_call, wr_hi, wr_lo, rd_lo, rd_hi, accept, op_ok;

  assign op_ok  = (cmd_op >= OP_PUSH) && (cmd_op <= OP_RST);
  assign busy   = cnt != 4'd0;
  assign accept = cmd_valid && !busy && op_ok;

  always_comb begin
    case (op_q)
      OP_PUSH, OP_PUSHF, OP_RET, OP_RETI, OP_JP, OP_RST: len = 4'd4;
      OP_POP, OP_POPF: len = 4'd3;
      OP_CALL: len = 4'd6;
      default: len = 4'd1;
    endcase
  end

  assign done      = busy && (cnt == len);
  assign push_like = (op_q == OP_PUSH) || (op_q == OP_PUSHF) || (op_q == OP_RST);
  assign is_call   = op_q == OP_CALL;
  assign pop_like  = (op_q == OP_POP) || (op_q == OP_POPF) || (op_q == OP_RET) || (op_q == OP_RETI);
  assign wr_hi     = busy && ((push_like && cnt == 4'd2) || (is_call && cnt == 4'd4));
  assign wr_lo     = busy && ((push_like && cnt == 4'd3) || (is_call && cnt == 4'd5));
  assign rd_lo     = busy && pop_like && cnt == 4'd1;
  assign rd_hi     = busy && pop_like && cnt == 4'd2;
  assign mem_we    = wr_hi || wr_lo;
  assign mem_re    = rd_lo || rd_hi;
  assign mem_addr  = mem_we ? sp - 1'b1 : sp;
  assign mem_wdata = wr_hi ? data_q[AW-1:DW] : data_q[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; op_q <= '0; tgt_q <= '0; data_q <= '0;
      lo_q <= '0; hi_q <= '0; sp <= SP_INIT; pc <= PC_INIT; ime <= 1'b0; pop_pair <= '0;
    end else begin
      if (accept) begin
        cnt  <= 4'd1;
        op_q <= cmd_op;
        case (cmd_op)
          OP_PUSHF: data_q <= {cmd_pair[AW-1:DW], cmd_pair[DW-1:DW-4], {(DW-4){1'b0}}};
          OP_CALL:  data_q <= pc + AW'(3);
          OP_RST:   data_q <= pc + AW'(1);
          default:  data_q <= cmd_pair;
        endcase
        tgt_q <= (cmd_op == OP_RST) ? {{(AW-6){1'b0}}, cmd_target[2:0], 3'b000} : cmd_target;
      end else if (done) begin
        cnt <= '0;
      end else if (busy) begin
        cnt <= cnt + 4'd1;
      end
      if (mem_we) sp <= sp - 1'b1;
      else if (mem_re) sp <= sp + 1'b1;
      if (rd_lo) lo_q <= mem_rdata;
      if (rd_hi) hi_q <= mem_rdata;
      if (done) begin
        case (op_q)
          OP_CALL, OP_JP, OP_RST: pc <= tgt_q;
          OP_RET:  pc <= {hi_q, lo_q};
          OP_RETI: begin pc <= {hi_q, lo_q}; ime <= 1'b1; end
          OP_JPR:  pc <= data_q;
          OP_POP:  pop_pair <= {hi_q, lo_q};
          OP_POPF: pop_pair <= {hi_q, lo_q[DW-1:DW-4], {(DW-4){1'b0}}};
          default: ;
        endcase
      end
    end
  end

  assert_bus_excl_R12: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));
  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(pc));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  assert_sp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(sp));
  assert_ime_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
                                      (done && op_q == OP_RETI) |=> ime);
  assert_push_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
                                       (done && op_q == OP_PUSH) |-> $past(wr_lo));
endmodule

// File: tb/tb_stack_flow_seq.sv
module tb_stack_flow_seq;
  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [3:0] cmd_op = 0;
  logic [15:0] cmd_target = 0, cmd_pair = 0;
  logic [7:0] mem_rdata, mem_wdata;
  logic [15:0] mem_addr, sp, pc, pop_pair;
  logic mem_we, mem_re, busy, done, ime;
  logic [7:0] mem [0:255];
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  stack_flow_seq dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cmd_pair(cmd_pair), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done),
    .sp(sp), .pc(pc), .ime(ime), .pop_pair(pop_pair));

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  typedef struct packed {
    logic [3:0] op; logic [15:0] tgt; logic [15:0] pair; logic [7:0] len;
    logic [15:0] sp; logic [15:0] pc; logic chk_out; logic [15:0] out;
    logic [7:0] ca; logic [7:0] cb;
  } vec_t;

  localparam vec_t TAB [10] = '{
    '{4'd1,  16'h0000, 16'h1234, 8'd4, 16'hFFFC, 16'h0100, 1'b0, 16'h0000, 8'hFC, 8'h34},
    '{4'd2,  16'h0000, 16'hA5B7, 8'd4, 16'hFFFA, 16'h0100, 1'b0, 16'h0000, 8'hFA, 8'hB0},
    '{4'd4,  16'h0000, 16'h0000, 8'd3, 16'hFFFC, 16'h0100, 1'b1, 16'hA5B0, 8'hFB, 8'hA5},
    '{4'd3,  16'h0000, 16'h0000, 8'd3, 16'hFFFE, 16'h0100, 1'b1, 16'h1234, 8'hFD, 8'h12},
    '{4'd5,  16'h2000, 16'h0000, 8'd6, 16'hFFFC, 16'h2000, 1'b0, 16'h0000, 8'hFC, 8'h03},
    '{4'd10, 16'h0003, 16'h0000, 8'd4, 16'hFFFA, 16'h0018, 1'b0, 16'h0000, 8'hFB, 8'h20},
    '{4'd6,  16'h0000, 16'h0000, 8'd4, 16'hFFFC, 16'h2001, 1'b0, 16'h0000, 8'hFA, 8'h01},
    '{4'd7,  16'h0000, 16'h0000, 8'd4, 16'hFFFE, 16'h0103, 1'b0, 16'h0000, 8'hFD, 8'h01},
    '{4'd8,  16'h4567, 16'h0000, 8'd4, 16'hFFFE, 16'h4567, 1'b0, 16'h0000, 8'hFF, 8'h00},
    '{4'd9,  16'h0000, 16'h89AB, 8'd1, 16'hFFFE, 16'h89AB, 1'b0, 16'h0000, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [3:0] op, input logic [15:0] tgt, input logic [15:0] pr,
                         output int len);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_target = tgt; cmd_pair = pr;
    @(posedge clk); #1 cmd_valid = 0;
    len = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      len++;
      if (done) break;
    end
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1 sp", sp, 16'hFFFE);
    check("R1 pc", pc, 16'h0100);
    check("R1 ime/busy/done/we/re", {ime, busy, done, mem_we, mem_re}, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 10; i++) begin
      run_cmd(TAB[i].op, TAB[i].tgt, TAB[i].pair, len);
      check($sformatf("R3 length op %0d", TAB[i].op), len, TAB[i].len);
      check($sformatf("R4 R6 R11 sp op %0d", TAB[i].op), sp, TAB[i].sp);
      check($sformatf("R8 R9 R10 pc op %0d", TAB[i].op), pc, TAB[i].pc);
      check($sformatf("R5 R8 R11 byte op %0d", TAB[i].op), mem[TAB[i].ca], TAB[i].cb);
      if (TAB[i].chk_out) check($sformatf("R6 R7 pop_pair op %0d", TAB[i].op), pop_pair, TAB[i].out);
      if (TAB[i].op == 4'd6) check("R9 ime after plain return", ime, 0);
      if (TAB[i].op == 4'd7) check("R9 ime after return-enable", ime, 1);
    end

    // R2: commands while busy are ignored
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'd1; cmd_pair = 16'h5A5A;
    @(posedge clk); #1 cmd_op = 4'd8; cmd_target = 16'h7777;
    len = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); len++;
      if (done) begin cmd_valid = 0; break; end
    end
    @(posedge clk); #1;
    check("R2 busy command ignored pc", pc, 16'h89AB);
    check("R2 push length with busy command", len, 4);
    check("R2 sp after push", sp, 16'hFFFC);
    @(negedge clk);
    check("R2 no accept after done", busy, 0);

    // R2: unused code ignored
    cmd_valid = 1; cmd_op = 4'd12; cmd_target = 16'h1111;
    @(posedge clk); #1 cmd_valid = 0;
    @(negedge clk);
    check("R2 unused code busy", busy, 0);
    check("R2 unused code pc", pc, 16'h89AB);
    check("R2 unused code sp", sp, 16'hFFFC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule